// File: doc/BRIEF.md
# Quadrature Lock-In Demodulator

This block recovers the in-phase and quadrature components of a weak tone buried in a sampled sensor signal. A phase-accumulator oscillator, clocked on the fast system clock and advanced once per sample strobe, produces a sine and a cosine from a single phase value. The sine is sent out as an offset-binary code for an external converter that excites the sensor. The cosine and the negated sine are the mixing references for the returning samples, so excitation and demodulation stay phase-coherent by construction.

Every accepted sample is multiplied by both references at full product precision. Each of the two products then passes through its own first-order recursive low-pass filter. The filtered pair is presented with a valid strobe a fixed number of cycles after each sample. A steady tone at the tuning frequency with amplitude A and phase offset φ against the reference settles to I ≈ (A·P/2)·cos φ and Q ≈ (A·P/2)·sin φ, where P = 2047 is the oscillator peak code. Magnitude, angle or position arithmetic downstream is left to the consumer.

Top module: `lockin_demod`

## Requirements
- R1: Reset is synchronous and active high. It clears the phase accumulator and both filter states. The cycle after reset shows i_out = 0, q_out = 0, iq_valid = 0 and dac_code = 0x800 (midscale).
- R2: iq_valid is high exactly three clock cycles after each cycle in which adc_valid is sampled high, and it is low in every other cycle.
- R3: The phase accumulator advances by ftw only on cycles with adc_valid high. dac_code holds while adc_valid is low, and idle cycles between samples do not change the demodulated result.
- R4: The oscillator phase p is the top 10 bits of the 32-bit accumulator. The sine sample is round(2047·sin(2π(p+0.5)/1024)), with quarter-wave symmetry, and the cosine is the same table read at p+256. dac_code is the sine sample with its sign bit inverted, registered on each strobe. After reset with ftw = 0x4000_0000, four strobes in a row give 0x806, 0xFFF, 0x7FA and 0x001, and no strobe ever leaves 0x800.
- R5: For samples x[n] = A·cos(2π·acc_n/2^32 + φ), with acc_n the accumulator value before the nth advance, the settled i_out is within 3 % of A·2047/2 of (A·2047/2)·cos φ.
- R6: Under the same stimulus, the settled q_out is within the same tolerance of (A·2047/2)·sin φ.
- R7: The products are kept at 24 bits: I = x·cos and Q = −(x·sin). Each filter realises y += (x − y) >> K with enough guard bits that a constant product settles to exactly that value without wrapping. With ftw = 0 and x = −2048 this gives i_out = −4192256 and q_out = 12288. With x = 2047 it gives i_out = 4190209 and q_out = −12282.
- R8: i_out and q_out change only in cycles where iq_valid is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the tone frequency |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | 32 | Frequency tuning word added to the phase per sample |
| adc_valid | input | 1 | Sample strobe |
| adc_data | input | 12 | Signed two's-complement sensor sample |
| dac_code | output | 12 | Offset-binary excitation reference (sine) |
| iq_valid | output | 1 | Filtered result strobe |
| i_out | output | 24 | Signed in-phase baseband output |
| q_out | output | 24 | Signed quadrature baseband output |

## Verification
The bench builds the block with the default 32-bit phase, 10-bit table address and 12-bit data paths, and with the filter shift K set to 8. At that shift the ripple at twice the tone frequency shrinks below one percent, which makes a 3 % tolerance on the settled I/Q a meaningful test of sign and phase across several tuning words. The recursion also settles to a constant product bit-exactly within a few thousand samples, so the full-scale no-overflow cases are checked for exact values. With the 10-bit table, the four quarter-turn reference codes are small, known integers that can be compared one strobe at a time.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

    localparam int PHASE_W_DEF = 32;
    localparam int LUT_W_DEF   = 10;
    localparam int ADC_W_DEF   = 12;
    localparam int NCO_W_DEF   = 12;
    localparam int FILT_K_DEF  = 6;

    localparam real HALF_PI = 1.5707963267948966;

    // Quadrant of the oscillator phase, taken from its two top bits.
    typedef enum logic [1:0] {
        QD_RISE  = 2'd0,
        QD_FALL  = 2'd1,
        QD_DIP   = 2'd2,
        QD_CLIMB = 2'd3
    } quadrant_e;

    // Largest positive code of a signed word of w bits.
    function automatic int peak_code(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

    // Sine by odd power series; argument stays within [0, pi/2].
    function automatic real series_sin(input real x);
        real term;
        real sum;
        term = x;
        sum  = x;
        for (int k = 1; k <= 9; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return sum;
    endfunction

    // Entry idx of a first-quadrant table, centred half a step into its bin.
    function automatic int qw_sample(input int idx, input int idx_w, input int peak);
        real ang;
        ang = HALF_PI * (real'(idx) + 0.5) / real'(1 << idx_w);
        return $rtoi(real'(peak) * series_sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/lockin_qwave.sv
module lockin_qwave #(
    parameter int LUT_W = 10,
    parameter int NCO_W = 12
) (
    input  logic [LUT_W-1:0]        phase,
    output logic signed [NCO_W-1:0] sample
);
    import lockin_pkg::*;

    localparam int IDX_W = LUT_W - 2;
    localparam int QTR   = 1 << IDX_W;
    localparam int PEAK  = peak_code(NCO_W);

    logic signed [NCO_W-1:0] rom [QTR];

    for (genvar i = 0; i < QTR; i++) begin : g_rom
        localparam int V = qw_sample(i, IDX_W, PEAK);
        assign rom[i] = NCO_W'(V);
    end

    quadrant_e               quad;
    logic [IDX_W-1:0]        idx;
    logic [IDX_W-1:0]        addr;
    logic signed [NCO_W-1:0] mag;

    always_comb begin
        quad = quadrant_e'(phase[LUT_W-1 -: 2]);
        idx  = phase[IDX_W-1:0];
        case (quad)
            QD_FALL, QD_CLIMB: addr = ~idx;
            default:           addr = idx;
        endcase
        mag = rom[addr];
        if (quad == QD_DIP || quad == QD_CLIMB) begin
            sample = -mag;
        end else begin
            sample = mag;
        end
    end

endmodule

// File: rtl/lockin_nco.sv
module lockin_nco #(
    parameter int PHASE_W = 32,
    parameter int LUT_W   = 10,
    parameter int NCO_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    advance,
    input  logic [PHASE_W-1:0]      ftw,
    output logic signed [NCO_W-1:0] sin_o,
    output logic signed [NCO_W-1:0] cos_o
);
    localparam int QTR  = 1 << (LUT_W - 2);
    localparam int TAPS = 2;

    logic [PHASE_W-1:0]      acc;
    logic [LUT_W-1:0]        ph_base;
    logic signed [NCO_W-1:0] wave [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (advance) begin
            acc <= acc + ftw;
        end
    end

    assign ph_base = acc[PHASE_W-1 -: LUT_W];

    // Tap 0 reads the sine, tap 1 the same table a quarter turn ahead.
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        logic [LUT_W-1:0] ph;
        assign ph = ph_base + LUT_W'(g * QTR);
        lockin_qwave #(
            .LUT_W(LUT_W),
            .NCO_W(NCO_W)
        ) u_qw (
            .phase (ph),
            .sample(wave[g])
        );
    end

    assign sin_o = wave[0];
    assign cos_o = wave[1];

endmodule

// File: rtl/lockin_mixer.sv
module lockin_mixer #(
    parameter int ADC_W = 12,
    parameter int NCO_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic signed [ADC_W-1:0]       x_in,
    input  logic signed [NCO_W-1:0]       sin_in,
    input  logic signed [NCO_W-1:0]       cos_in,
    output logic [NCO_W-1:0]              dac_code,
    output logic                          prod_valid,
    output logic signed [ADC_W+NCO_W-1:0] prod_i,
    output logic signed [ADC_W+NCO_W-1:0] prod_q
);
    localparam int PROD_W = ADC_W + NCO_W;
    localparam logic [NCO_W-1:0] MIDSCALE = {1'b1, {(NCO_W-1){1'b0}}};

    logic                    s1_valid;
    logic signed [ADC_W-1:0] s1_x;
    logic signed [NCO_W-1:0] s1_sin;
    logic signed [NCO_W-1:0] s1_cos;
    logic signed [PROD_W-1:0] mul_i;
    logic signed [PROD_W-1:0] mul_s;

    // Stage 1: capture sample and reference pair, update excitation code.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
            s1_sin   <= '0;
            s1_cos   <= '0;
            dac_code <= MIDSCALE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_x     <= x_in;
                s1_sin   <= sin_in;
                s1_cos   <= cos_in;
                dac_code <= {~sin_in[NCO_W-1], sin_in[NCO_W-2:0]};
            end
        end
    end

    always_comb begin
        mul_i = PROD_W'(s1_x) * PROD_W'(s1_cos);
        mul_s = PROD_W'(s1_x) * PROD_W'(s1_sin);
    end

    // Stage 2: full-precision products, quadrature arm negated.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_valid <= 1'b0;
            prod_i     <= '0;
            prod_q     <= '0;
        end else begin
            prod_valid <= s1_valid;
            if (s1_valid) begin
                prod_i <= mul_i;
                prod_q <= -mul_s;
            end
        end
    end

endmodule

// File: rtl/lockin_lpf.sv
module lockin_lpf #(
    parameter int IN_W = 24,
    parameter int K    = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [IN_W-1:0] x,
    output logic signed [IN_W-1:0] y
);
    localparam int ST_W = IN_W + K + 1;

    logic signed [ST_W-1:0] st;
    logic signed [ST_W-1:0] x_ext;
    logic signed [ST_W-1:0] leak;

    always_comb begin
        x_ext = {{(K + 1){x[IN_W-1]}}, x};
        leak  = st >>> K;
    end

    // State holds y scaled by 2^K: st += x - (st >> K).
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (en) begin
            st <= st + x_ext - leak;
        end
    end

    assign y = st[K +: IN_W];

endmodule

// File: rtl/lockin_demod.sv
module lockin_demod #(
    parameter int PHASE_W = lockin_pkg::PHASE_W_DEF,
    parameter int LUT_W   = lockin_pkg::LUT_W_DEF,
    parameter int ADC_W   = lockin_pkg::ADC_W_DEF,
    parameter int NCO_W   = lockin_pkg::NCO_W_DEF,
    parameter int FILT_K  = lockin_pkg::FILT_K_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PHASE_W-1:0]            ftw,
    input  logic                          adc_valid,
    input  logic signed [ADC_W-1:0]       adc_data,
    output logic [NCO_W-1:0]              dac_code,
    output logic                          iq_valid,
    output logic signed [ADC_W+NCO_W-1:0] i_out,
    output logic signed [ADC_W+NCO_W-1:0] q_out
);
    localparam int PROD_W = ADC_W + NCO_W;
    localparam int ARMS   = 2;

    logic signed [NCO_W-1:0]  nco_sin;
    logic signed [NCO_W-1:0]  nco_cos;
    logic                     prod_valid;
    logic signed [PROD_W-1:0] prod [ARMS];
    logic signed [PROD_W-1:0] filt [ARMS];
    logic                     out_valid_q;

    lockin_nco #(
        .PHASE_W(PHASE_W),
        .LUT_W  (LUT_W),
        .NCO_W  (NCO_W)
    ) u_nco (
        .clk    (clk),
        .rst    (rst),
        .advance(adc_valid),
        .ftw    (ftw),
        .sin_o  (nco_sin),
        .cos_o  (nco_cos)
    );

    lockin_mixer #(
        .ADC_W(ADC_W),
        .NCO_W(NCO_W)
    ) u_mix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (adc_valid),
        .x_in      (adc_data),
        .sin_in    (nco_sin),
        .cos_in    (nco_cos),
        .dac_code  (dac_code),
        .prod_valid(prod_valid),
        .prod_i    (prod[0]),
        .prod_q    (prod[1])
    );

    for (genvar a = 0; a < ARMS; a++) begin : g_arm
        lockin_lpf #(
            .IN_W(PROD_W),
            .K   (FILT_K)
        ) u_lpf (
            .clk(clk),
            .rst(rst),
            .en (prod_valid),
            .x  (prod[a]),
            .y  (filt[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= prod_valid;
        end
    end

    assign iq_valid = out_valid_q;
    assign i_out    = filt[0];
    assign q_out    = filt[1];

endmodule

// File: rtl/lockin_checks.sv
module lockin_checks #(
    parameter int ADC_W = 12,
    parameter int NCO_W = 12
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          adc_valid,
    input logic [NCO_W-1:0]              dac_code,
    input logic                          iq_valid,
    input logic signed [ADC_W+NCO_W-1:0] i_out,
    input logic signed [ADC_W+NCO_W-1:0] q_out
);
    localparam logic [NCO_W-1:0] MIDSCALE = {1'b1, {(NCO_W-1){1'b0}}};

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!iq_valid && i_out == '0 && q_out == '0 && dac_code == MIDSCALE));

    // R2
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        adc_valid |-> ##3 iq_valid);

    // R2
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        iq_valid |-> $past(adc_valid, 3));

    // R3
    a_r3_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> $stable(dac_code));

    // R4
    a_r4_no_midscale: assert property (@(posedge clk) disable iff (rst)
        adc_valid |=> dac_code != MIDSCALE);

    // R8
    a_r8_output_hold: assert property (@(posedge clk) disable iff (rst)
        !iq_valid |-> ($stable(i_out) && $stable(q_out)));

endmodule

bind lockin_demod lockin_checks #(
    .ADC_W(ADC_W),
    .NCO_W(NCO_W)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .adc_valid(adc_valid),
    .dac_code (dac_code),
    .iq_valid (iq_valid),
    .i_out    (i_out),
    .q_out    (q_out)
);

// File: tb/tb_lockin_demod.sv
module tb_lockin_demod;

    localparam int  ADC_W  = 12;
    localparam int  NCO_W  = 12;
    localparam int  PROD_W = ADC_W + NCO_W;
    localparam int  FILT_K = 8;
    localparam int  NSAMP  = 3000;
    localparam int  NFULL  = 5000;
    localparam real TWO_PI = 6.283185307179586;
    localparam real PEAK   = 2047.0;

    typedef struct packed {
        int          amp;
        int          ph;
        logic [31:0] f;
        logic        gap;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1800,   0, 32'h1000_0000, 1'b0},
        '{1800,  90, 32'h1000_0000, 1'b0},
        '{1500, 180, 32'h0800_0000, 1'b0},
        '{1200, 300, 32'h0C00_0000, 1'b0},
        '{1800,  45, 32'h1000_0000, 1'b1},
        '{2000, 210, 32'h0A3D_70A4, 1'b0}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [31:0]              ftw = '0;
    logic                     adc_valid = 1'b0;
    logic signed [ADC_W-1:0]  adc_data = '0;
    logic [NCO_W-1:0]         dac_code;
    logic                     iq_valid;
    logic signed [PROD_W-1:0] i_out;
    logic signed [PROD_W-1:0] q_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lockin_demod #(
        .FILT_K(FILT_K)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .ftw      (ftw),
        .adc_valid(adc_valid),
        .adc_data (adc_data),
        .dac_code (dac_code),
        .iq_valid (iq_valid),
        .i_out    (i_out),
        .q_out    (q_out)
    );

    function automatic int rnd(input real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what, input longint act,
                            input real exp, input real tol);
        real d;
        n_chk++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0.1f (tol %0.1f)", req, what, act, exp, tol);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        adc_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        chk_eq("R1", {tag, " i_out"}, i_out, 0);
        chk_eq("R1", {tag, " q_out"}, q_out, 0);
        chk_eq("R1", {tag, " iq_valid"}, longint'(iq_valid), 0);
        chk_eq("R1", {tag, " dac_code"}, longint'(dac_code), 'h800);
    endtask

    task automatic run_tone(input int amp, input int ph, input logic [31:0] f,
                            input logic gap, input int n);
        logic [31:0] a;
        real         ang;
        a   = '0;
        ftw = f;
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            ang       = TWO_PI * real'(a) / 4294967296.0 + TWO_PI * real'(ph) / 360.0;
            adc_valid = 1'b1;
            adc_data  = ADC_W'(rnd(real'(amp) * $cos(ang)));
            a         = a + f;
            if (gap) begin
                @(negedge clk);
                adc_valid = 1'b0;
            end
        end
        @(negedge clk);
        adc_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_const(input int x, input int n);
        ftw = '0;
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            adc_valid = 1'b1;
            adc_data  = ADC_W'(x);
        end
        @(negedge clk);
        adc_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint hold_i;
        longint hold_q;

        // R1: state right after the first reset
        do_reset();
        check_reset_state("initial");

        // R2: a single strobe yields one result strobe three cycles later
        adc_valid = 1'b1;
        adc_data  = '0;
        @(negedge clk);
        adc_valid = 1'b0;
        chk_eq("R2", "iq_valid +1", longint'(iq_valid), 0);
        @(negedge clk);
        chk_eq("R2", "iq_valid +2", longint'(iq_valid), 0);
        @(negedge clk);
        chk_eq("R2", "iq_valid +3", longint'(iq_valid), 1);
        @(negedge clk);
        chk_eq("R2", "iq_valid +4", longint'(iq_valid), 0);

        // R4: quarter-turn steps walk the reference through its four codes
        do_reset();
        ftw       = 32'h4000_0000;
        adc_valid = 1'b1;
        @(negedge clk);
        chk_eq("R4", "dac step0", longint'(dac_code), 'h806);
        @(negedge clk);
        chk_eq("R4", "dac step1", longint'(dac_code), 'hFFF);
        @(negedge clk);
        chk_eq("R4", "dac step2", longint'(dac_code), 'h7FA);
        @(negedge clk);
        chk_eq("R4", "dac step3", longint'(dac_code), 'h001);
        adc_valid = 1'b0;
        // R3: reference holds while no strobe arrives
        repeat (5) @(negedge clk);
        chk_eq("R3", "dac idle hold", longint'(dac_code), 'h001);

        // R5, R6 (and R3 for the gapped vector): table of tones
        for (int v = 0; v < NVEC; v++) begin
            real scale;
            real e_i;
            real e_q;
            real tol;
            do_reset();
            run_tone(VECS[v].amp, VECS[v].ph, VECS[v].f, VECS[v].gap, NSAMP);
            scale = real'(VECS[v].amp) * PEAK / 2.0;
            e_i   = scale * $cos(TWO_PI * real'(VECS[v].ph) / 360.0);
            e_q   = scale * $sin(TWO_PI * real'(VECS[v].ph) / 360.0);
            tol   = 0.03 * scale;
            chk_near(VECS[v].gap ? "R3" : "R5", $sformatf("vec%0d i_out", v), i_out, e_i, tol);
            chk_near(VECS[v].gap ? "R3" : "R6", $sformatf("vec%0d q_out", v), q_out, e_q, tol);

            if (v == 0) begin
                // R8: outputs hold while no result strobe
                hold_i = i_out;
                hold_q = q_out;
                repeat (10) @(negedge clk);
                chk_eq("R8", "i_out hold", i_out, hold_i);
                chk_eq("R8", "q_out hold", q_out, hold_q);
                chk_eq("R8", "iq_valid idle", longint'(iq_valid), 0);
            end
        end

        // R1: reset in mid-run clears filled filters
        do_reset();
        check_reset_state("mid-run");

        // R7: full-scale constants settle exactly without wrapping
        run_const(-2048, NFULL);
        chk_eq("R7", "neg full i_out", i_out, -4192256);
        chk_eq("R7", "neg full q_out", q_out, 12288);
        do_reset();
        run_const(2047, NFULL);
        chk_eq("R7", "pos full i_out", i_out, 4190209);
        chk_eq("R7", "pos full q_out", q_out, -12282);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule